// File: doc/BRIEF.md
# Clock-Enable Divider Tree with Oscillator/PLL Modes

This block runs entirely on one fast clock and turns it into single-cycle enable strobes for a set of peripheral reference rates: a timer base, two prescaled timers, a PWM base, an SPI base, a selectable SPI bit rate and a UART rate. No derived clock is produced. Downstream logic qualifies its own registers with these strobes.

The input clock is either a fixed external oscillator or a PLL output. A mode input tells the block which one is present, and the first-stage divide ratios follow that choice. Second-stage dividers then refine the timer and SPI strobes according to small select fields that arrive as plain inputs. A three-state controller tracks the mode. `ST_INIT` is the state held in reset; it leaves on the first clock after release through `INIT_TO_EXT` or `INIT_TO_PLL`. Once running, the controller moves between `ST_EXT` and `ST_PLL` through `EXT_TO_PLL` and `PLL_TO_EXT` whenever the mode input flips. In the cycle where the mode input disagrees with the state, every divider is cleared and all strobes are held low. A change in a select field clears only the dividers that field feeds.

Timing convention used below: cycle 0 is the first cycle with reset low, or the cycle in which a mode or select input takes its new value. A strobe with overall ratio P, counted from a cleared divider, is high in cycle k exactly when k > 0 and k is a multiple of P.

Top module: `clken_tree`

## Requirements
- R1: While `rst` is high every strobe is low. After release, each strobe follows the timing convention with its overall ratio, so cycle 0 carries no strobe.
- R2: With `ext_mode` = 1, `spiref_en` divides the clock by 96 and `pwm_en` divides it by 128.
- R3: With `ext_mode` = 1, `tref_en` divides the clock by 26 when `tbase_sel` = 1 and by 24 when `tbase_sel` = 0.
- R4: With `ext_mode` = 0, `spiref_en` divides by 576, `pwm_en` by 768 and `tref_en` by 144, whatever the value of `tbase_sel`.
- R5: `spi_en` divides `spiref_en` further by 32, 8, 2 or 1 for `spi_rate` codes 0, 1, 2 and 3, and is only ever high in a cycle where `spiref_en` is high.
- R6: `t1_en` and `t2_en` each divide `tref_en` by 256 when their own prescale bit (`t1_pre`, `t2_pre`) is 0 and pass it at /1 when it is 1. Each is only high together with `tref_en`.
- R7: `uart_en` is one tenth of the bus rate. The bus rate is the clock in oscillator mode and half the clock in PLL mode, so the overall ratio is 10 or 20.
- R8: Every strobe is a single-cycle pulse and is never high in two consecutive cycles.
- R9: In the cycle where `ext_mode` changes, all strobes are low. All dividers restart, so every strobe follows the timing convention with the new mode's ratios.
- R10: A change of `spi_rate`, `t1_pre`/`t2_pre`, or (in oscillator mode only) `tbase_sel` restarts only the dependent second stage or timer chain. The restarted stage counts its source strobes from cycle 1. Strobes not fed by that field keep their period and phase. A `tbase_sel` change in PLL mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 = external oscillator clock, 0 = PLL clock |
| tbase_sel | input | 1 | Oscillator-mode timer base: 1 = /26, 0 = /24 |
| spi_rate | input | 2 | SPI rate code: 0 /32, 1 /8, 2 /2, 3 /1 |
| t1_pre | input | 1 | Timer 1 prescale: 0 = /256, 1 = /1 |
| t2_pre | input | 1 | Timer 2 prescale: 0 = /256, 1 = /1 |
| tref_en | output | 1 | Timer reference strobe |
| t1_en | output | 1 | Timer 1 strobe |
| t2_en | output | 1 | Timer 2 strobe |
| pwm_en | output | 1 | PWM reference strobe |
| spiref_en | output | 1 | SPI reference strobe |
| spi_en | output | 1 | Final SPI rate strobe |
| uart_en | output | 1 | UART rate strobe |

## Verification
The bench shrinks the first-stage ratios: SPI base 6 or 9, PWM base 8 or 12, timer base 3/5 or 7, timer prescale 4. It keeps the SPI code table and the UART ratio of ten unchanged. With these values, all 64 combinations of mode, timer base, SPI code and both prescale bits each show several full periods of every strobe within 600 cycles. The slowest strobe, SPI at 9×32, fits twice in that window. This makes an exhaustive sweep of the configuration space affordable. Directed runs then flip the mode and individual select fields without reset, so restart isolation and phase preservation can be measured from the port strobes alone.

// File: rtl/clken_pkg.sv
package clken_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_EXT  = 2'd1,
        ST_PLL  = 2'd2
    } mode_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/clken_div.sv
// Strobe-driven counter: emits one pulse per RATIO source strobes.
module clken_div #(
    parameter int MAX_RATIO = 256,
    parameter int CW        = $clog2(MAX_RATIO + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] ratio,
    output logic          pulse
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CW-1:0] cnt;
    logic          at_end;

    assign at_end = (cnt == ratio - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_end ? '0 : cnt + CW'(1);
        end
    end

    // A cleared or restarting stage never emits.
    assign pulse = tick && at_end && !restart && !rst;

    // R8: the count stays inside the active ratio whenever the stage runs
    p_cnt_below_ratio_r8 : assert property (@(posedge clk) disable iff (rst)
        !restart |-> (cnt < ratio));

    // R10: an idle, non-restarting stage holds its count
    p_hold_without_tick_r10 : assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt));
endmodule

// File: rtl/clken_mode_fsm.sv
// Mode controller: tracks oscillator/PLL mode and derives restart requests.
module clken_mode_fsm
    import clken_pkg::*;
#(
    parameter int NTMR = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_mode,
    input  logic            tbase_sel,
    input  logic [1:0]      spi_rate,
    input  logic [NTMR-1:0] tmr_pre,
    output mode_e           state,
    output logic            rs_all,
    output logic            rs_tref,
    output logic            rs_spi,
    output logic [NTMR-1:0] rs_tmr
);
    timeunit 1ns;
    timeprecision 1ps;

    mode_e           nxt;
    logic            tbase_q;
    logic [1:0]      spi_q;
    logic [NTMR-1:0] pre_q;
    logic            mode_rs;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_INIT;
        end else begin
            state <= nxt;
        end
    end

    // Previous select values, captured every cycle including reset
    always_ff @(posedge clk) begin
        tbase_q <= tbase_sel;
        spi_q   <= spi_rate;
        pre_q   <= tmr_pre;
    end

    // Transitions: INIT_TO_EXT, INIT_TO_PLL, EXT_TO_PLL, PLL_TO_EXT
    always_comb begin
        nxt = state;
        unique case (state)
            ST_INIT: nxt = ext_mode ? ST_EXT : ST_PLL;
            ST_EXT:  if (!ext_mode) nxt = ST_PLL;
            ST_PLL:  if (ext_mode)  nxt = ST_EXT;
            default: nxt = ST_INIT;
        endcase
    end

    // Restart outputs
    always_comb begin
        mode_rs = 1'b1;
        unique case (state)
            ST_INIT: mode_rs = 1'b1;
            ST_EXT:  mode_rs = !ext_mode;
            ST_PLL:  mode_rs = ext_mode;
            default: mode_rs = 1'b1;
        endcase
        rs_all  = mode_rs || rst;
        rs_tref = rs_all || ((state == ST_EXT) && (tbase_sel != tbase_q));
        rs_spi  = rs_all || (spi_rate != spi_q);
        for (int i = 0; i < NTMR; i++) begin
            rs_tmr[i] = rs_tref || (tmr_pre[i] != pre_q[i]);
        end
    end

    // R1: the boot state lasts exactly one cycle after release
    p_init_exit_r1 : assert property (@(posedge clk) disable iff (rst)
        (state == ST_INIT) |=> (state != ST_INIT));

    // R9: a running state always agrees with the mode seen one cycle earlier
    p_state_tracks_mode_r9 : assert property (@(posedge clk) disable iff (rst)
        (state != ST_INIT) |-> ((state == ST_EXT) == $past(ext_mode)));
endmodule

// File: rtl/clken_tree.sv
module clken_tree
    import clken_pkg::*;
#(
    parameter int EXT_SPI_DIV   = 96,
    parameter int EXT_PWM_DIV   = 128,
    parameter int EXT_TMR_DIV_A = 24,
    parameter int EXT_TMR_DIV_B = 26,
    parameter int PLL_SPI_DIV   = 576,
    parameter int PLL_PWM_DIV   = 768,
    parameter int PLL_TMR_DIV   = 144,
    parameter int PLL_BUS_DIV   = 2,
    parameter int UART_DIV      = 10,
    parameter int TMR_PRE_DIV   = 256,
    parameter int SPI_DIV_C0    = 32,
    parameter int SPI_DIV_C1    = 8,
    parameter int SPI_DIV_C2    = 2,
    parameter int SPI_DIV_C3    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_mode,
    input  logic       tbase_sel,
    input  logic [1:0] spi_rate,
    input  logic       t1_pre,
    input  logic       t2_pre,
    output logic       tref_en,
    output logic       t1_en,
    output logic       t2_en,
    output logic       pwm_en,
    output logic       spiref_en,
    output logic       spi_en,
    output logic       uart_en
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NTMR     = 2;
    localparam int TREF_MAX = imax(imax(EXT_TMR_DIV_A, EXT_TMR_DIV_B), PLL_TMR_DIV);
    localparam int SPIR_MAX = imax(EXT_SPI_DIV, PLL_SPI_DIV);
    localparam int PWM_MAX  = imax(EXT_PWM_DIV, PLL_PWM_DIV);
    localparam int BUS_MAX  = imax(1, PLL_BUS_DIV);
    localparam int SPI_MAX  = imax(imax(SPI_DIV_C0, SPI_DIV_C1), imax(SPI_DIV_C2, SPI_DIV_C3));
    localparam int TREF_W   = $clog2(TREF_MAX + 1);
    localparam int SPIR_W   = $clog2(SPIR_MAX + 1);
    localparam int PWM_W    = $clog2(PWM_MAX + 1);
    localparam int BUS_W    = $clog2(BUS_MAX + 1);
    localparam int SPI_W    = $clog2(SPI_MAX + 1);
    localparam int TPRE_W   = $clog2(TMR_PRE_DIV + 1);
    localparam int UART_W   = $clog2(UART_DIV + 1);

    mode_e            state;
    logic             rs_all;
    logic             rs_tref;
    logic             rs_spi;
    logic [NTMR-1:0]  rs_tmr;
    logic [NTMR-1:0]  tmr_pre;
    logic [NTMR-1:0]  tmr_pulse;
    logic             is_ext;
    logic             bus_p;
    logic [TREF_W-1:0] tref_r;
    logic [SPIR_W-1:0] spir_r;
    logic [PWM_W-1:0]  pwm_r;
    logic [BUS_W-1:0]  bus_r;
    logic [SPI_W-1:0]  spi_r;
    logic [6:0]        all_en;

    assign tmr_pre = {t2_pre, t1_pre};

    clken_mode_fsm #(.NTMR(NTMR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .tbase_sel(tbase_sel),
        .spi_rate (spi_rate),
        .tmr_pre  (tmr_pre),
        .state    (state),
        .rs_all   (rs_all),
        .rs_tref  (rs_tref),
        .rs_spi   (rs_spi),
        .rs_tmr   (rs_tmr)
    );

    // Ratio selection: first stages follow the settled mode state
    always_comb begin
        is_ext = (state == ST_EXT);
        if (is_ext) begin
            tref_r = tbase_sel ? TREF_W'(EXT_TMR_DIV_B) : TREF_W'(EXT_TMR_DIV_A);
            spir_r = SPIR_W'(EXT_SPI_DIV);
            pwm_r  = PWM_W'(EXT_PWM_DIV);
            bus_r  = BUS_W'(1);
        end else begin
            tref_r = TREF_W'(PLL_TMR_DIV);
            spir_r = SPIR_W'(PLL_SPI_DIV);
            pwm_r  = PWM_W'(PLL_PWM_DIV);
            bus_r  = BUS_W'(PLL_BUS_DIV);
        end
        unique case (spi_rate)
            2'd0: spi_r = SPI_W'(SPI_DIV_C0);
            2'd1: spi_r = SPI_W'(SPI_DIV_C1);
            2'd2: spi_r = SPI_W'(SPI_DIV_C2);
            2'd3: spi_r = SPI_W'(SPI_DIV_C3);
            default: spi_r = SPI_W'(SPI_DIV_C0);
        endcase
    end

    // First stages, ticking every clock
    clken_div #(.MAX_RATIO(TREF_MAX)) u_tref (
        .clk(clk), .rst(rst), .restart(rs_tref), .tick(1'b1),
        .ratio(tref_r), .pulse(tref_en));

    clken_div #(.MAX_RATIO(SPIR_MAX)) u_spiref (
        .clk(clk), .rst(rst), .restart(rs_all), .tick(1'b1),
        .ratio(spir_r), .pulse(spiref_en));

    clken_div #(.MAX_RATIO(PWM_MAX)) u_pwm (
        .clk(clk), .rst(rst), .restart(rs_all), .tick(1'b1),
        .ratio(pwm_r), .pulse(pwm_en));

    clken_div #(.MAX_RATIO(BUS_MAX)) u_bus (
        .clk(clk), .rst(rst), .restart(rs_all), .tick(1'b1),
        .ratio(bus_r), .pulse(bus_p));

    // Second stages
    clken_div #(.MAX_RATIO(SPI_MAX)) u_spi (
        .clk(clk), .rst(rst), .restart(rs_spi), .tick(spiref_en),
        .ratio(spi_r), .pulse(spi_en));

    clken_div #(.MAX_RATIO(UART_DIV)) u_uart (
        .clk(clk), .rst(rst), .restart(rs_all), .tick(bus_p),
        .ratio(UART_W'(UART_DIV)), .pulse(uart_en));

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        logic [TPRE_W-1:0] pre_r;
        assign pre_r = tmr_pre[g] ? TPRE_W'(1) : TPRE_W'(TMR_PRE_DIV);
        clken_div #(.MAX_RATIO(TMR_PRE_DIV)) u_pre (
            .clk(clk), .rst(rst), .restart(rs_tmr[g]), .tick(tref_en),
            .ratio(pre_r), .pulse(tmr_pulse[g]));
    end

    assign t1_en = tmr_pulse[0];
    assign t2_en = tmr_pulse[1];

    assign all_en = {uart_en, spi_en, spiref_en, pwm_en, t2_en, t1_en, tref_en};

    // R1: nothing strobes while reset is held
    p_quiet_in_reset_r1 : assert property (@(posedge clk)
        rst |-> (all_en == '0));

    // R8: no strobe is high in two consecutive cycles
    p_single_cycle_r8 : assert property (@(posedge clk) disable iff (rst)
        (|all_en) |=> ((all_en & $past(all_en)) == '0));

    // R9: the cycle in which the mode input flips carries no strobe
    p_mode_quiet_r9 : assert property (@(posedge clk) disable iff (rst)
        !$stable(ext_mode) |-> (all_en == '0));

    // R5: the SPI rate strobe coincides with a SPI reference strobe
    p_spi_on_ref_r5 : assert property (@(posedge clk) disable iff (rst)
        spi_en |-> spiref_en);

    // R6: timer strobes coincide with a timer reference strobe
    p_tmr_on_tref_r6 : assert property (@(posedge clk) disable iff (rst)
        (t1_en || t2_en) |-> tref_en);
endmodule

// File: tb/tb_clken_tree.sv
module tb_clken_tree;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int B_EXT_SPI = 6;
    localparam int B_EXT_PWM = 8;
    localparam int B_EXT_TA  = 3;
    localparam int B_EXT_TB  = 5;
    localparam int B_PLL_SPI = 9;
    localparam int B_PLL_PWM = 12;
    localparam int B_PLL_TMR = 7;
    localparam int B_TPRE    = 4;
    localparam int WIN       = 600;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_mode = 1'b0;
    logic       tbase_sel = 1'b0;
    logic [1:0] spi_rate = 2'd0;
    logic       t1_pre = 1'b0;
    logic       t2_pre = 1'b0;
    logic       tref_en, t1_en, t2_en, pwm_en, spiref_en, spi_en, uart_en;
    logic [6:0] outs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [6:0] hist [0:1023];

    always #2 clk = ~clk;

    clken_tree #(
        .EXT_SPI_DIV(B_EXT_SPI), .EXT_PWM_DIV(B_EXT_PWM),
        .EXT_TMR_DIV_A(B_EXT_TA), .EXT_TMR_DIV_B(B_EXT_TB),
        .PLL_SPI_DIV(B_PLL_SPI), .PLL_PWM_DIV(B_PLL_PWM),
        .PLL_TMR_DIV(B_PLL_TMR), .TMR_PRE_DIV(B_TPRE)
    ) dut (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .tbase_sel(tbase_sel),
        .spi_rate(spi_rate), .t1_pre(t1_pre), .t2_pre(t2_pre),
        .tref_en(tref_en), .t1_en(t1_en), .t2_en(t2_en), .pwm_en(pwm_en),
        .spiref_en(spiref_en), .spi_en(spi_en), .uart_en(uart_en)
    );

    // index: 0 tref, 1 t1, 2 t2, 3 pwm, 4 spiref, 5 spi, 6 uart
    assign outs = {uart_en, spi_en, spiref_en, pwm_en, t2_en, t1_en, tref_en};

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int spi_code_div(input int code);
        case (code)
            0: return 32;
            1: return 8;
            2: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic int period(input int idx, input bit m, input bit tb,
                                  input int sr, input bit p1, input bit p2);
        int tref, spir;
        tref = m ? (tb ? B_EXT_TB : B_EXT_TA) : B_PLL_TMR;
        spir = m ? B_EXT_SPI : B_PLL_SPI;
        case (idx)
            0: return tref;
            1: return tref * (p1 ? 1 : B_TPRE);
            2: return tref * (p2 ? 1 : B_TPRE);
            3: return m ? B_EXT_PWM : B_PLL_PWM;
            4: return spir;
            5: return spir * spi_code_div(sr);
            default: return (m ? 1 : 2) * 10;
        endcase
    endfunction

    task automatic do_reset(input bit m, input bit tb, input int sr,
                            input bit p1, input bit p2);
        @(posedge clk); #1;
        rst = 1'b1;
        ext_mode = m; tbase_sel = tb; spi_rate = 2'(sr); t1_pre = p1; t2_pre = p2;
        @(posedge clk); @(posedge clk); #1;
        check(outs == 7'd0, "R1", "strobes during reset", int'(outs), 0);
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    // Entered at posedge+1; change of kind applied at the start of cycle 0.
    task automatic run(input int pre, input int len, input int kind, input int val);
        for (int k = -pre; k < len; k++) begin
            if (k == 0) begin
                case (kind)
                    1: ext_mode  = val[0];
                    2: spi_rate  = 2'(val);
                    3: t1_pre    = val[0];
                    4: tbase_sel = val[0];
                    default: ;
                endcase
            end
            #1;
            hist[k + pre] = outs;
            @(posedge clk); #1;
        end
    endtask

    task automatic chk_period(input int idx, input int p, input int pre,
                              input int len, input string tag);
        int bad = 0, fk = -1, fa = 0, fe = 0;
        for (int k = 0; k < len; k++) begin
            int obs, e;
            obs = int'(hist[k + pre][idx]);
            e   = (k > 0 && (k % p) == 0) ? 1 : 0;
            if (obs != e) begin
                bad++;
                if (fk < 0) begin fk = k; fa = obs; fe = e; end
            end
        end
        check(bad == 0, tag,
              $sformatf("strobe %0d ratio %0d, first wrong cycle %0d", idx, p, fk), fa, fe);
    endtask

    task automatic chk_gap(input int idx, input int p, input int pre,
                           input int len, input string tag);
        int last = 0, have = 0, bad = 0, badgap = p, n = 0;
        for (int k = -pre; k < len; k++) begin
            if (hist[k + pre][idx]) begin
                n++;
                if (have != 0 && (k - last) != p) begin
                    bad++;
                    badgap = k - last;
                end
                last = k;
                have = 1;
            end
        end
        check(bad == 0 && n >= 2, tag,
              $sformatf("strobe %0d spacing across change (pulses %0d)", idx, n), badgap, p);
    endtask

    task automatic chk_sub(input int oi, input int ii, input int div, input int pre,
                           input int len, input string tag);
        int cnt = 0, bad = 0, fk = -1, fa = 0, fe = 0;
        for (int k = 0; k < len; k++) begin
            int src, obs, e;
            src = int'(hist[k + pre][ii]);
            obs = int'(hist[k + pre][oi]);
            if (k > 0 && src != 0) cnt++;
            e = (k > 0 && src != 0 && (cnt % div) == 0) ? 1 : 0;
            if (obs != e) begin
                bad++;
                if (fk < 0) begin fk = k; fa = obs; fe = e; end
            end
        end
        check(bad == 0, tag,
              $sformatf("strobe %0d restarted /%0d, first wrong cycle %0d", oi, div, fk), fa, fe);
    endtask

    task automatic chk_single(input int pre, input int len);
        int bad = 0;
        logic [6:0] both = '0;
        for (int k = 1; k < pre + len; k++) begin
            if ((hist[k] & hist[k - 1]) != 7'd0) begin
                bad++;
                both = hist[k] & hist[k - 1];
            end
        end
        check(bad == 0, "R8", "strobe high two cycles in a row", int'(both), 0);
    endtask

    initial begin
        repeat (2) @(posedge clk);

        // Exhaustive sweep: every mode/select combination from reset (R1-R7)
        for (int cfg = 0; cfg < 64; cfg++) begin
            bit m, tb, p1, p2;
            int sr;
            m  = cfg[0];
            tb = cfg[1];
            sr = (cfg >> 2) & 3;
            p1 = cfg[4];
            p2 = cfg[5];
            do_reset(m, tb, sr, p1, p2);
            run(0, WIN, 0, 0);
            chk_period(0, period(0, m, tb, sr, p1, p2), 0, WIN, m ? "R3" : "R4");
            chk_period(1, period(1, m, tb, sr, p1, p2), 0, WIN, "R6");
            chk_period(2, period(2, m, tb, sr, p1, p2), 0, WIN, "R6");
            chk_period(3, period(3, m, tb, sr, p1, p2), 0, WIN, m ? "R2" : "R4");
            chk_period(4, period(4, m, tb, sr, p1, p2), 0, WIN, m ? "R2" : "R4");
            chk_period(5, period(5, m, tb, sr, p1, p2), 0, WIN, "R5");
            chk_period(6, period(6, m, tb, sr, p1, p2), 0, WIN, "R7");
            chk_single(0, WIN);
        end

        // R9: mode flips without reset restart every divider
        do_reset(1'b1, 1'b1, 1, 1'b0, 1'b1);
        run(0, 57, 0, 0);
        run(0, WIN, 1, 0);
        for (int i = 0; i < 7; i++) chk_period(i, period(i, 1'b0, 1'b1, 1, 1'b0, 1'b1), 0, WIN, "R9");
        chk_single(0, WIN);
        run(0, 33, 0, 0);
        run(0, WIN, 1, 1);
        for (int i = 0; i < 7; i++) chk_period(i, period(i, 1'b1, 1'b1, 1, 1'b0, 1'b1), 0, WIN, "R9");

        // R10: SPI code change restarts only the SPI stage
        do_reset(1'b1, 1'b0, 0, 1'b0, 1'b0);
        run(0, 41, 0, 0);
        run(40, 400, 2, 2);
        chk_sub(5, 4, 2, 40, 400, "R10");
        chk_gap(4, B_EXT_SPI, 40, 400, "R10");
        chk_gap(3, B_EXT_PWM, 40, 400, "R10");
        chk_gap(6, 10, 40, 400, "R10");

        // R10: timer 1 prescale change leaves timer base and timer 2 alone
        do_reset(1'b0, 1'b0, 3, 1'b1, 1'b0);
        run(0, 45, 0, 0);
        run(40, 400, 3, 0);
        chk_sub(1, 0, B_TPRE, 40, 400, "R10");
        chk_gap(2, B_PLL_TMR * B_TPRE, 40, 400, "R10");
        chk_gap(0, B_PLL_TMR, 40, 400, "R10");

        // R10/R4: timer base select is ignored in PLL mode
        run(40, 400, 4, 1);
        chk_gap(0, B_PLL_TMR, 40, 400, "R10");
        chk_gap(1, B_PLL_TMR * B_TPRE, 40, 400, "R10");
        chk_gap(2, B_PLL_TMR * B_TPRE, 40, 400, "R10");

        // R10: timer base select change in oscillator mode restarts the timer chain
        do_reset(1'b1, 1'b0, 0, 1'b1, 1'b0);
        run(0, 20, 0, 0);
        run(0, WIN, 4, 1);
        chk_period(0, B_EXT_TB, 0, WIN, "R10");
        chk_period(1, B_EXT_TB, 0, WIN, "R10");
        chk_period(2, B_EXT_TB * B_TPRE, 0, WIN, "R10");
        chk_gap(3, B_EXT_PWM, 0, WIN, "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule